// File: doc/BRIEF.md
# Rewindable FIFO with half-full status

This block is a single-clock first-in first-out buffer for 9-bit words, 256, 512 or 1024 entries deep. Writers and readers issue one-cycle strobes. Two ring pointers address the storage, so neither side supplies an address. Full, empty and half-full outputs tell each side when it must hold off.

A rewind input, active low, moves the read pointer back to location zero and leaves the write pointer where it is. A block of data written since reset can then be sent again from its first word. Read data comes from a register and is marked by a one-cycle valid pulse. Any strobe the buffer refuses raises a one-cycle error pulse.

Top module: `rewind_fifo`

## Requirements
- R1: Words leave the buffer in the order they were accepted, 9 bits wide. DEPTH is a power of two (256, 512 or 1024).
- R2: A clock edge with `rst_n` low sets both pointers to location zero. From the next cycle, `empty` is 1 and `full`, `half_full`, `rd_valid` and `err` are 0.
- R3: A write strobe while `full` is 1 is refused. The refused word never appears at the output, and stored words are unchanged.
- R4: A read strobe while `empty` is 1 is refused. No valid pulse follows, and the read pointer does not move.
- R5: With no reads after reset, `full` rises after exactly DEPTH accepted writes and not before. One accepted read clears `full`, and the next write is then accepted.
- R6: `half_full` is 1 exactly while the occupancy exceeds DEPTH/2. It rises on the write that takes the occupancy past DEPTH/2, and it falls on the read that brings the occupancy back to DEPTH/2 or less.
- R7: A cycle with `rt_n` low returns the read pointer to location zero and leaves the write pointer alone. Later reads replay the words from the first one written after reset, and later writes append after the last word written.
- R8: After a rewind, the occupancy equals the number of words written since reset. It is capped at DEPTH when the write pointer has wrapped. All three flags follow this new occupancy from the next cycle.
- R9: An accepted read puts the word on `rd_data` and raises `rd_valid` for one cycle, both in the cycle after the strobe. `rd_valid` is never 1 otherwise.
- R10: `err` pulses for one cycle after any refused strobe. Refused strobes are a write while full, a read while empty, and any strobe in a rewind cycle. A strobe given during a rewind has no effect on the data.
- R11: When a read and a write are both accepted in the same cycle, the occupancy and all three flags stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all strobes sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rt_n | input | 1 | Rewind of the read pointer, active low |
| rd_data | output | 9 | Registered read word |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| half_full | output | 1 | Occupancy above DEPTH/2 |
| err | output | 1 | One-cycle pulse after a refused strobe |

## Verification
The assertions check the following on every cycle:
- the flag state after reset;
- that a full or empty buffer stays put when only a refused strobe arrives;
- that `half_full` moves only after a write, a read or a rewind;
- that `rd_valid` always traces back to an accepted read;
- that every refused strobe produces an error pulse;
- that flags hold steady across a simultaneous read and write.

The word order, the exact write count at which `full` rises, the replayed data after a rewind, the occupancy rebuilt after a wrapped rewind, and the absence of a refused word all need a reference queue. Only the bench's directed scenarios can show these.

// File: rtl/rewind_fifo_pkg.sv
// Package: types shared by the rewindable FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rewind_fifo_pkg;

    // Per-cycle decision derived from the strobes and the current flags
    typedef struct packed {
        logic wr_ok;   // write accepted this cycle
        logic rd_ok;   // read accepted this cycle
        logic rewind;  // read pointer returns to zero this cycle
        logic bad;     // some strobe was refused this cycle
    } fifo_ctl_t;

endpackage

// File: rtl/rf_arbiter.sv
// Module: decides which strobes are accepted in the current cycle.
// Assumes: flags come from registered state; rewind beats both strobes.
module rf_arbiter
    import rewind_fifo_pkg::*;
(
    input  logic      wr_en,
    input  logic      rd_en,
    input  logic      rt_n,
    input  logic      full,
    input  logic      empty,
    output fifo_ctl_t ctl
);

    // Accept a strobe only outside a rewind and only while its flag allows it
    always_comb begin
        ctl.rewind = !rt_n;
        ctl.wr_ok  = rt_n && wr_en && !full;
        ctl.rd_ok  = rt_n && rd_en && !empty;
        ctl.bad    = (wr_en && !ctl.wr_ok) || (rd_en && !ctl.rd_ok);
    end

endmodule

// File: rtl/rf_pointers.sv
// Module: ring pointers, wrap marker and occupancy counter.
// Assumes: DEPTH is a power of two; synchronous active-low reset.
module rf_pointers
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_ctl_t        ctl,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);

    logic wrapped;

    // Advance the write side and remember that it passed the last location
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (ctl.wr_ok) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
            if (wr_ptr == PTR_W'(DEPTH - 1)) begin
                wrapped <= 1'b1;
            end
        end
    end

    // Move the read side and keep the occupancy; a rewind rebuilds it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else if (ctl.rewind) begin
            rd_ptr <= '0;
            count  <= wrapped ? CNT_W'(DEPTH) : {1'b0, wr_ptr};
        end else begin
            if (ctl.rd_ok) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            count <= count + CNT_W'(ctl.wr_ok) - CNT_W'(ctl.rd_ok);
        end
    end

endmodule

// File: rtl/rf_store.sv
// Module: word storage with a registered read port and valid pulse.
// Assumes: write and read never hit the same word in one cycle (read refused when empty).
module rf_store
    import rewind_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fifo_ctl_t         ctl,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted word at the write pointer
    always_ff @(posedge clk) begin
        if (ctl.wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Register the word at the read pointer and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= ctl.rd_ok;
            if (ctl.rd_ok) begin
                rd_data <= mem[rd_ptr];
            end
        end
    end

endmodule

// File: rtl/rf_flags.sv
// Module: decodes the three status flags from the occupancy counter.
// Assumes: count never exceeds DEPTH.
module rf_flags #(
    parameter int DEPTH = 512,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             half_full
);

    // Compare the occupancy with its three thresholds
    always_comb begin
        empty     = (count == '0);
        full      = (count == CNT_W'(DEPTH));
        half_full = (count > CNT_W'(HALF));
    end

endmodule

// File: rtl/rewind_fifo.sv
// Module: single-clock FIFO with a read-pointer rewind and half-full flag.
// Assumes: DEPTH is a power of two; strobes are one word per cycle on clk.
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rt_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              empty,
    output logic              half_full,
    output logic              err
);

    fifo_ctl_t        ctl;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    rf_arbiter u_arb (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rt_n  (rt_n),
        .full  (full),
        .empty (empty),
        .ctl   (ctl)
    );

    rf_pointers #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (ctl),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count)
    );

    rf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    rf_flags #(.DEPTH(DEPTH)) u_flg (
        .count     (count),
        .full      (full),
        .empty     (empty),
        .half_full (half_full)
    );

    // Raise a one-cycle error pulse after any refused strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= ctl.bad;
        end
    end

endmodule

// File: rtl/rewind_fifo_chk.sv
// Module: cycle-by-cycle properties of the rewindable FIFO, bound to its top.
// Assumes: observes top-level ports only.
module rewind_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic rt_n,
    input logic rd_valid,
    input logic full,
    input logic empty,
    input logic half_full,
    input logic err
);

    assert_reset_flags_R2: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !half_full && !rd_valid && !err));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rt_n && !rd_en) |=> full);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rt_n && !wr_en) |=> (empty && !rd_valid));

    assert_flag_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_half_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_full) |-> ($past(wr_en) || $past(!rt_n)));

    assert_half_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_full) |-> ($past(rd_en) || $past(!rt_n) || $past(!rst_n)));

    assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && rt_n && !empty));

    assert_reject_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en && full && rt_n) || (rd_en && empty && rt_n) || (!rt_n && (wr_en || rd_en)))
        |=> err);

    assert_balanced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && rt_n && !full && !empty)
        |=> ($stable(full) && $stable(empty) && $stable(half_full)));

endmodule

bind rewind_fifo rewind_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rt_n      (rt_n),
    .rd_valid  (rd_valid),
    .full      (full),
    .empty     (empty),
    .half_full (half_full),
    .err       (err)
);

// File: tb/test_rewind_fifo.sv
// Bench: directed scenarios against a queue model of the requirements.
module test_rewind_fifo;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rt_n = 1'b1;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       full;
    logic       empty;
    logic       half_full;
    logic       err;

    int checks = 0;
    int errors = 0;
    logic [8:0] mq[$];
    logic [8:0] hist[$];

    always #2 clk = ~clk;

    rewind_fifo #(.DEPTH(DEPTH)) i_rewind_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rt_n(rt_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .full(full), .empty(empty), .half_full(half_full), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, empty, mq.size() == 0);
        chk(req, full, mq.size() == DEPTH);
        chk(req, half_full, mq.size() > DEPTH / 2);
    endtask

    // One clock: drive at a falling edge, check at the next falling edge
    task automatic cyc(input bit wr, input logic [8:0] wd, input bit rd,
                       input bit rt, input string req);
        int   sz;
        bit   wr_ok;
        bit   rd_ok;
        logic [8:0] exp_d;
        sz = mq.size();
        exp_d = '0;
        wr_en = wr; wr_data = wd; rd_en = rd; rt_n = !rt;
        @(negedge clk);
        wr_ok = wr && !rt && (sz < DEPTH);
        rd_ok = rd && !rt && (sz > 0);
        if (rt) mq = hist;
        if (rd_ok) exp_d = mq.pop_front();
        if (wr_ok) begin
            mq.push_back(wd);
            hist.push_back(wd);
        end
        chk(req, rd_valid, rd_ok);
        if (rd_ok) chk(req, rd_data, exp_d);
        chk({req, "/R10"}, err, (wr && !wr_ok) || (rd && !rd_ok));
        chk_flags(req);
        wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        hist.delete();
        @(negedge clk);
    endtask

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) & 9'h1FF);
    endfunction

    task automatic fill(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) cyc(1'b1, pat(base + i), 1'b0, 1'b0, req);
    endtask

    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b1, 1'b0, req);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2", rd_valid, 0);
        chk("R2", err, 0);
        chk_flags("R2");
    endtask

    task automatic t_order();
        do_reset();
        cyc(1'b1, 9'h0A5, 1'b0, 1'b0, "R1");
        cyc(1'b1, 9'h1FF, 1'b0, 1'b0, "R1");
        cyc(1'b1, 9'h000, 1'b0, 1'b0, "R1");
        drain(3, "R9");
        cyc(1'b0, '0, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_underflow();
        do_reset();
        cyc(1'b0, '0, 1'b1, 1'b0, "R4");
        cyc(1'b1, 9'h123, 1'b0, 1'b0, "R4");
        drain(2, "R4");
    endtask

    task automatic t_half();
        do_reset();
        fill(DEPTH / 2, 0, "R6");
        cyc(1'b1, 9'h055, 1'b0, 1'b0, "R6");
        drain(1, "R6");
        cyc(1'b1, 9'h066, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_full();
        do_reset();
        fill(DEPTH, 100, "R5");
        cyc(1'b1, 9'h1EE, 1'b0, 1'b0, "R3");
        drain(1, "R5");
        cyc(1'b1, 9'h0AA, 1'b0, 1'b0, "R5");
        cyc(1'b1, 9'h1DD, 1'b1, 1'b0, "R3");
        drain(DEPTH, "R3");
    endtask

    task automatic t_simul();
        do_reset();
        cyc(1'b1, 9'h011, 1'b1, 1'b0, "R11");
        fill(2, 7, "R11");
        for (int i = 0; i < 3; i++) cyc(1'b1, pat(50 + i), 1'b1, 1'b0, "R11");
        drain(3, "R11");
    endtask

    task automatic t_rewind();
        do_reset();
        fill(5, 200, "R7");
        drain(3, "R7");
        cyc(1'b0, '0, 1'b0, 1'b1, "R8");
        drain(5, "R7");
        cyc(1'b1, 9'h137, 1'b0, 1'b0, "R7");
        drain(1, "R7");
    endtask

    task automatic t_rewind_strobe();
        do_reset();
        fill(2, 300, "R10");
        cyc(1'b1, 9'h1AB, 1'b0, 1'b1, "R10");
        cyc(1'b0, '0, 1'b1, 1'b1, "R10");
        drain(3, "R10");
    endtask

    task automatic t_rewind_full();
        do_reset();
        fill(DEPTH, 400, "R8");
        drain(10, "R8");
        cyc(1'b0, '0, 1'b0, 1'b1, "R8");
        drain(2, "R8");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_underflow();
        t_half();
        t_full();
        t_simul();
        t_rewind();
        t_rewind_strobe();
        t_rewind_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule